// File: doc/BRIEF.md
# Scatter-Gather Parameter Set Builder

This block converts a single scatter-gather segment request into one packed three-dimensional DMA parameter set. A request carries the source and destination addresses, the element width in bytes, the burst length in elements, the segment length in bytes, a two-bit direction code, a channel slot number and a flag that marks the final segment of a list. The block picks a transfer mode from the burst length. It derives the element, frame and block counts with a shared sequential divider. It then sets up the strides for the memory side of the transfer and presents the packed words on its output.

A burst of exactly one element selects element-synchronized mode. In this mode a long segment is split into full frames of 65535 elements plus one partial frame. A longer burst selects frame-synchronized mode. Here each frame is one burst, and a block count that does not fit in sixteen bits is rejected. The device side of the transfer always gets zero strides. Requests and results each pass through a valid/ready handshake, and the block holds one request at a time.

Top module: `sg_pset_builder`

## Requirements
- R1: `in_ready` is high only when no request is in progress and no result is pending. Each accepted request yields exactly one result cycle with `out_valid` high and `out_ready` high. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R2: The low 16 bits of `cnt_ab_word` carry the element width, called the A count.
- R3: When burst = 1 (element mode), let q = length / width. The C count is q / 65535 and the B count is q mod 65535. When that remainder is nonzero, the C count is incremented by one. When it is zero, the B count becomes 65535. The frame stride equals the width.
- R4: When burst > 1 (frame mode), the B count is the burst and the C count is length / (width × burst). The frame stride is the low 16 bits of width × burst. A C count above 65535 is an error.
- R5: Each index word packs the destination stride in bits [31:16] and the source stride in bits [15:0]. For direction 2'b01 (memory to device), the source element stride is the width and the source frame stride is the frame stride, and both destination strides are zero. For direction 2'b10 (device to memory), the destination takes those strides and the source strides are zero.
- R6: `link_word` is 32'hFFFF_FFFF. `opt_word` bits [17:12] carry the slot number. `opt_word` bit 2 and `frame_sync` are set only in frame mode. `cnt_ab_word` carries the B count in bits [31:16]. `ccnt_word` carries the C count.
- R7: `opt_word` bit 20 is set only when `last_seg` was set on the request.
- R8: Any of the following makes the result an error: a width of 0, a burst of 0, a direction of 2'b00 or 2'b11, or the R4 overflow. An error result has `err` = 1, and every parameter word and `frame_sync` are zero, during its single result cycle.
- R9: On a result without error, `src_word` and `dst_word` equal the request's source and destination addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| src_addr | input | 32 | Source address |
| dst_addr | input | 32 | Destination address |
| elem_width | input | 16 | Element width in bytes |
| burst_len | input | 16 | Burst length in elements |
| seg_len | input | 32 | Segment length in bytes |
| dir | input | 2 | 01 memory to device, 10 device to memory |
| slot | input | 6 | Channel completion code |
| last_seg | input | 1 | Final segment of a list |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| opt_word | output | 32 | Option word |
| src_word | output | 32 | Source address word |
| dst_word | output | 32 | Destination address word |
| idx_b_word | output | 32 | Element stride word |
| idx_c_word | output | 32 | Frame stride word |
| cnt_ab_word | output | 32 | B and A count word |
| ccnt_word | output | 32 | C count word |
| link_word | output | 32 | Link and B reload word |
| frame_sync | output | 1 | Frame-synchronized mode |
| err | output | 1 | Request rejected |

## Verification
The assertions assume that requests arrive only through the handshake. They also assume that `out_ready` is the only input that matters while a result waits. The divider checks further assume that it is never started with a zero divisor, which holds because the error checks filter such requests out before the divider is started. The stimulus drives requests only when `in_ready` is high and holds `in_valid` low during processing. It stalls `out_ready` for a varying number of cycles before taking each result.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_M2D  = 2'b01,
    DIR_D2M  = 2'b10,
    DIR_BAD  = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV1,
    ST_DIV2,
    ST_OUT
  } st_e;

  localparam int OPT_SYNC_BIT = 2;
  localparam int OPT_CODE_LSB = 12;
  localparam int OPT_IRQ_BIT  = 20;
  localparam int OPT_W        = 32;
endpackage

// File: rtl/sgp_divider.sv
module sgp_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    rem_q, rem_d, quo_q, quo_d, div_q, div_d, dvd_q, dvd_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            busy_q, busy_d, done_q, done_d;
  logic [W:0]      trial;
  logic [W:0]      diff;

  assign trial = {rem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, div_q};

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    div_d  = div_q;
    dvd_d  = dvd_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start_i) begin
      rem_d  = '0;
      quo_d  = dividend_i;
      div_d  = divisor_i;
      dvd_d  = dividend_i;
      cnt_d  = CNTW'(W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (trial >= {1'b0, div_q}) begin
        rem_d = diff[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      div_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      div_q  <= div_d;
      dvd_q  <= dvd_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
  assign rem_o  = rem_q;

  // R8: errors are filtered before a division is started
  p_div_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> divisor_i != '0);

  // R3: remainder below divisor at completion
  p_div_rem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> rem_o < div_q);

  // R3: quotient and remainder reconstruct the dividend
  p_div_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ({{W{1'b0}}, quot_o} * {{W{1'b0}}, div_q} + {{W{1'b0}}, rem_o})
               == {{W{1'b0}}, dvd_q});
endmodule

// File: rtl/sgp_packer.sv
module sgp_packer
  import sgp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int LW = 32,
  parameter int SW = 6
) (
  input  logic              err_i,
  input  logic              frame_i,
  input  logic              m2d_i,
  input  logic              last_i,
  input  logic [SW-1:0]     slot_i,
  input  logic [CW-1:0]     acnt_i,
  input  logic [CW-1:0]     bcnt_i,
  input  logic [LW-1:0]     ccnt_i,
  input  logic [CW-1:0]     cidx_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  output logic [OPT_W-1:0]  opt_o,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [2*CW-1:0]   idx_b_o,
  output logic [2*CW-1:0]   idx_c_o,
  output logic [2*CW-1:0]   cnt_ab_o,
  output logic [LW-1:0]     ccnt_o,
  output logic [2*CW-1:0]   link_o,
  output logic              frame_o
);
  logic [CW-1:0] sb, sc, db, dc;

  always_comb begin
    if (m2d_i) begin
      sb = acnt_i;
      sc = cidx_i;
      db = '0;
      dc = '0;
    end else begin
      sb = '0;
      sc = '0;
      db = acnt_i;
      dc = cidx_i;
    end
  end

  always_comb begin
    opt_o    = '0;
    src_o    = '0;
    dst_o    = '0;
    idx_b_o  = '0;
    idx_c_o  = '0;
    cnt_ab_o = '0;
    ccnt_o   = '0;
    link_o   = '0;
    frame_o  = 1'b0;
    if (!err_i) begin
      opt_o[OPT_CODE_LSB +: SW] = slot_i;
      opt_o[OPT_SYNC_BIT]       = frame_i;
      opt_o[OPT_IRQ_BIT]        = last_i;
      src_o    = src_i;
      dst_o    = dst_i;
      idx_b_o  = {db, sb};
      idx_c_o  = {dc, sc};
      cnt_ab_o = {bcnt_i, acnt_i};
      ccnt_o   = ccnt_i;
      link_o   = '1;
      frame_o  = frame_i;
    end
  end
endmodule

// File: rtl/sg_pset_builder.sv
module sg_pset_builder
  import sgp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int LW = 32,
  parameter int SW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     src_addr,
  input  logic [AW-1:0]     dst_addr,
  input  logic [CW-1:0]     elem_width,
  input  logic [CW-1:0]     burst_len,
  input  logic [LW-1:0]     seg_len,
  input  logic [1:0]        dir,
  input  logic [SW-1:0]     slot,
  input  logic              last_seg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OPT_W-1:0]  opt_word,
  output logic [AW-1:0]     src_word,
  output logic [AW-1:0]     dst_word,
  output logic [2*CW-1:0]   idx_b_word,
  output logic [2*CW-1:0]   idx_c_word,
  output logic [2*CW-1:0]   cnt_ab_word,
  output logic [LW-1:0]     ccnt_word,
  output logic [2*CW-1:0]   link_word,
  output logic              frame_sync,
  output logic              err
);
  localparam int PW = 2 * CW;
  localparam logic [LW-1:0] CNT_MAX = LW'((64'd1 << CW) - 64'd1);

  st_e           st_q, st_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] w_q, w_d, b_q, b_d, bcnt_q, bcnt_d, cidx_q, cidx_d;
  logic [LW-1:0] ccnt_q, ccnt_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          m2d_q, m2d_d, last_q, last_d, frame_q, frame_d, err_q, err_d;

  logic          acc, err_in, frame_in, dir_ok;
  logic [PW-1:0] prod;
  logic          div_start, div_done;
  logic [LW-1:0] div_a, div_b, quot, rem;

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_OUT);
  assign acc       = in_valid && in_ready;
  assign dir_ok    = (dir == DIR_M2D) || (dir == DIR_D2M);
  assign err_in    = (elem_width == '0) || (burst_len == '0) || !dir_ok;
  assign frame_in  = (burst_len != CW'(1));
  assign prod      = {{CW{1'b0}}, elem_width} * {{CW{1'b0}}, burst_len};

  assign div_start = (acc && !err_in) || ((st_q == ST_DIV1) && div_done && !frame_q);
  assign div_a     = (st_q == ST_IDLE) ? seg_len : quot;
  assign div_b     = (st_q != ST_IDLE) ? CNT_MAX :
                     (frame_in ? LW'(prod) : LW'(elem_width));

  sgp_divider #(.W(LW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (div_a),
    .divisor_i  (div_b),
    .done_o     (div_done),
    .quot_o     (quot),
    .rem_o      (rem)
  );

  always_comb begin
    st_d    = st_q;
    src_d   = src_q;
    dst_d   = dst_q;
    w_d     = w_q;
    b_d     = b_q;
    bcnt_d  = bcnt_q;
    cidx_d  = cidx_q;
    ccnt_d  = ccnt_q;
    slot_d  = slot_q;
    m2d_d   = m2d_q;
    last_d  = last_q;
    frame_d = frame_q;
    err_d   = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (acc) begin
          src_d   = src_addr;
          dst_d   = dst_addr;
          w_d     = elem_width;
          b_d     = burst_len;
          slot_d  = slot;
          m2d_d   = (dir == DIR_M2D);
          last_d  = last_seg;
          frame_d = frame_in;
          err_d   = err_in;
          bcnt_d  = '0;
          ccnt_d  = '0;
          cidx_d  = frame_in ? prod[CW-1:0] : elem_width;
          st_d    = err_in ? ST_OUT : ST_DIV1;
        end
      end
      ST_DIV1: begin
        if (div_done) begin
          if (frame_q) begin
            if (quot > CNT_MAX) begin
              err_d = 1'b1;
            end else begin
              ccnt_d = quot;
              bcnt_d = b_q;
            end
            st_d = ST_OUT;
          end else begin
            st_d = ST_DIV2;
          end
        end
      end
      ST_DIV2: begin
        if (div_done) begin
          ccnt_d = quot + LW'(rem != '0);
          bcnt_d = (rem != '0) ? rem[CW-1:0] : CNT_MAX[CW-1:0];
          st_d   = ST_OUT;
        end
      end
      ST_OUT: begin
        if (out_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      w_q     <= '0;
      b_q     <= '0;
      bcnt_q  <= '0;
      cidx_q  <= '0;
      ccnt_q  <= '0;
      slot_q  <= '0;
      m2d_q   <= 1'b0;
      last_q  <= 1'b0;
      frame_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      w_q     <= w_d;
      b_q     <= b_d;
      bcnt_q  <= bcnt_d;
      cidx_q  <= cidx_d;
      ccnt_q  <= ccnt_d;
      slot_q  <= slot_d;
      m2d_q   <= m2d_d;
      last_q  <= last_d;
      frame_q <= frame_d;
      err_q   <= err_d;
    end
  end

  sgp_packer #(.AW(AW), .CW(CW), .LW(LW), .SW(SW)) u_pack (
    .err_i    (err_q),
    .frame_i  (frame_q),
    .m2d_i    (m2d_q),
    .last_i   (last_q),
    .slot_i   (slot_q),
    .acnt_i   (w_q),
    .bcnt_i   (bcnt_q),
    .ccnt_i   (ccnt_q),
    .cidx_i   (cidx_q),
    .src_i    (src_q),
    .dst_i    (dst_q),
    .opt_o    (opt_word),
    .src_o    (src_word),
    .dst_o    (dst_word),
    .idx_b_o  (idx_b_word),
    .idx_c_o  (idx_c_word),
    .cnt_ab_o (cnt_ab_word),
    .ccnt_o   (ccnt_word),
    .link_o   (link_word),
    .frame_o  (frame_sync)
  );

  assign err = err_q;

  // R1: a pending result blocks new requests
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R1: outputs hold under back-pressure
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(opt_word) && $stable(src_word)
      && $stable(dst_word) && $stable(idx_b_word) && $stable(idx_c_word)
      && $stable(cnt_ab_word) && $stable(ccnt_word) && $stable(err));

  // R4: frame-mode C count fits in the count field
  p_ccnt_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err && frame_sync) |-> ccnt_word <= CNT_MAX);

  // R3: element-mode B count is never zero
  p_bcnt_nz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err && !frame_sync) |-> cnt_ab_word[PW-1:CW] != '0);

  // R6: sync bit follows the mode flag, link word is all ones
  p_sync_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err) |-> (opt_word[OPT_SYNC_BIT] == frame_sync) && (link_word == '1));

  // R8: an error result carries zero counts
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err) |-> (cnt_ab_word == '0) && (ccnt_word == '0) && !frame_sync);
endmodule

// File: tb/sg_pset_builder_test.sv
module sg_pset_builder_test;
  logic        clk, rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] src_addr, dst_addr, seg_len;
  logic [15:0] elem_width, burst_len;
  logic [1:0]  dir;
  logic [5:0]  slot;
  logic        last_seg;
  logic [31:0] opt_word, src_word, dst_word, idx_b_word, idx_c_word;
  logic [31:0] cnt_ab_word, ccnt_word, link_word;
  logic        frame_sync, err;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] e_opt, e_src, e_dst, e_ib, e_ic, e_ab, e_cc, e_link;
  logic        e_fs, e_err;

  sg_pset_builder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_addr(src_addr), .dst_addr(dst_addr), .elem_width(elem_width),
    .burst_len(burst_len), .seg_len(seg_len), .dir(dir), .slot(slot),
    .last_seg(last_seg), .out_valid(out_valid), .out_ready(out_ready),
    .opt_word(opt_word), .src_word(src_word), .dst_word(dst_word),
    .idx_b_word(idx_b_word), .idx_c_word(idx_c_word), .cnt_ab_word(cnt_ab_word),
    .ccnt_word(ccnt_word), .link_word(link_word), .frame_sync(frame_sync), .err(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] s, input logic [31:0] d, input int w,
                       input int b, input longint len, input int dr, input int sl,
                       input bit last);
    longint q, c, r, bc, cidx;
    bit fs, bad;
    bad = (w == 0) || (b == 0) || !(dr == 1 || dr == 2);
    fs = 0; c = 0; bc = 0; cidx = 0;
    if (!bad) begin
      if (b == 1) begin
        q = len / w;
        c = q / 65535;
        r = q % 65535;
        if (r != 0) c = c + 1;
        else r = 65535;
        bc = r;
        cidx = w;
      end else begin
        fs = 1;
        bc = b;
        c = len / (w * b);
        if (c > 65535) bad = 1;
        cidx = (w * b) % 65536;
      end
    end
    e_err = bad;
    if (bad) begin
      e_opt = 0; e_src = 0; e_dst = 0; e_ib = 0; e_ic = 0;
      e_ab = 0; e_cc = 0; e_link = 0; e_fs = 0;
    end else begin
      e_opt = (32'(sl) << 12) | (32'(fs) << 2) | (32'(last) << 20);
      e_src = s;
      e_dst = d;
      if (dr == 1) begin
        e_ib = 32'(w);
        e_ic = 32'(cidx);
      end else begin
        e_ib = 32'(w) << 16;
        e_ic = 32'(cidx) << 16;
      end
      e_ab = (32'(bc) << 16) | 32'(w);
      e_cc = 32'(c);
      e_link = 32'hFFFF_FFFF;
      e_fs = fs;
    end
  endtask

  task automatic compare_out();
    if (e_err) begin
      chk("R8 err", {31'd0, err}, 32'd1);
      chk("R8 cnt_ab", cnt_ab_word, 32'd0);
      chk("R8 ccnt", ccnt_word, 32'd0);
      chk("R8 opt", opt_word, 32'd0);
      chk("R8 frame_sync", {31'd0, frame_sync}, 32'd0);
    end else begin
      chk("R8 err", {31'd0, err}, 32'd0);
      chk("R6 R7 opt", opt_word, e_opt);
      chk("R9 src", src_word, e_src);
      chk("R9 dst", dst_word, e_dst);
      chk("R5 idx_b", idx_b_word, e_ib);
      chk("R3 R4 R5 idx_c", idx_c_word, e_ic);
      chk("R2 R3 R4 cnt_ab", cnt_ab_word, e_ab);
      chk("R3 R4 ccnt", ccnt_word, e_cc);
      chk("R6 link", link_word, e_link);
      chk("R6 frame_sync", {31'd0, frame_sync}, {31'd0, e_fs});
    end
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] d, input int w,
                     input int b, input longint len, input int dr, input int sl,
                     input bit last, input int stall);
    int st;
    st = stall;
    @(negedge clk);
    chk("R1 idle ready", {31'd0, in_ready}, 32'd1);
    src_addr = s; dst_addr = d; elem_width = 16'(w); burst_len = 16'(b);
    seg_len = 32'(len); dir = 2'(dr); slot = 6'(sl); last_seg = last;
    in_valid = 1'b1;
    model(s, d, w, b, len, dr, sl, last);
    @(negedge clk);
    in_valid = 1'b0;
    forever begin
      if (out_valid) begin
        chk("R1 busy ready", {31'd0, in_ready}, 32'd0);
        compare_out();
        if (st == 0) begin
          out_ready = 1'b1;
          @(negedge clk);
          out_ready = 1'b0;
          break;
        end
        st--;
      end else begin
        chk("R1 busy ready", {31'd0, in_ready}, 32'd0);
      end
      @(negedge clk);
    end
    chk("R1 single result", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    src_addr = 0; dst_addr = 0; elem_width = 0; burst_len = 0;
    seg_len = 0; dir = 0; slot = 0; last_seg = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    // R3 element mode, short segment, memory to device
    run(32'h1000_0000, 32'h4000_0010, 4, 1, 64, 1, 5, 0, 2);
    // R3 exact multiple of 65535 elements, remainder zero
    run(32'h2000_0000, 32'h4000_0020, 4, 1, 64'd65535 * 8, 1, 9, 1, 0);
    // R3 partial frame plus full frame, device to memory
    run(32'h4000_0030, 32'h3000_0000, 4, 1, 64'd4 * 65545, 2, 17, 0, 1);
    // R3 length below one element
    run(32'h5000_0000, 32'h4000_0040, 8, 1, 3, 1, 0, 1, 0);
    // R4 frame mode, memory to device
    run(32'h6000_0000, 32'h4000_0050, 4, 8, 320, 1, 33, 1, 3);
    // R4 frame mode, device to memory, truncated length
    run(32'h4000_0060, 32'h7000_0000, 2, 16, 1000, 2, 63, 0, 0);
    // R4 C count exactly at the limit
    run(32'h8000_0000, 32'h4000_0070, 1, 2, 131070, 1, 1, 0, 1);
    // R4 R8 C count one past the limit
    run(32'h8000_0000, 32'h4000_0070, 1, 2, 131072, 1, 1, 0, 2);
    // R8 zero width
    run(32'h9000_0000, 32'h4000_0080, 0, 1, 64, 1, 2, 1, 1);
    // R8 zero burst
    run(32'h9000_0000, 32'h4000_0080, 4, 0, 64, 2, 2, 1, 0);
    // R8 illegal direction codes
    run(32'h9000_0000, 32'h4000_0080, 4, 4, 64, 0, 2, 0, 0);
    run(32'h9000_0000, 32'h4000_0080, 4, 4, 64, 3, 2, 0, 1);
    // R5 R7 recovery after error, large frame stride truncated to 16 bits
    run(32'hA000_0000, 32'h4000_0090, 512, 256, 64'd131072 * 3, 1, 44, 1, 0);
    run(32'h4000_00A0, 32'hB000_0000, 2, 1, 64'd200000, 2, 12, 1, 2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule